// File: doc/BRIEF.md
# Load Value Replication Queue

This block keeps two redundant threads fed with identical cached-load inputs. The thread fixed as leading is the only one whose cached loads reach the data cache. Each value the cache returns to it is written, with its load address, into an in-order queue. The trailing thread never touches the cache. Each of its cached loads takes the oldest queue entry and receives the value stored there.

Both threads therefore consume the same value even when I/O or another processor changes memory between their two accesses, so no false fault is reported. The two threads' loads are never paired on a cache access. The leading thread runs ahead freely and is held back only when the queue has no free slot. On every pop, the trailing load's address is compared with the stored address. A difference is flagged as a fault together with the response.

The leading role belongs to the push port and the trailing role to the pop port. The assignment is wired and never changes. A trailing request is held by the requester until a cycle in which the queue is not empty. That cycle is the acceptance, and the response appears one clock later.

Top module: `load_echo_queue`

## Requirements
- R1: During and right after reset the queue is empty: `q_empty`=1, `q_full`=0, `lead_stall`=0, `trail_rsp_vld`=0 and `trail_fault`=0.
- R2: A leading return (`lead_vld`=1) is stored at the next rising edge whenever the queue is not full, whatever the trailing port does in that cycle.
- R3: With DEPTH entries held, `q_full` and `lead_stall` are 1 and a leading return in that cycle is not stored. Later pops show the queue contents unchanged.
- R4: A trailing request accepted in cycle N (`trail_vld`=1 with the queue not empty) yields `trail_rsp_vld`=1 in cycle N+1, with `trail_rsp_data` equal to the data of the oldest entry. Entries leave in the order they were stored.
- R5: A trailing request made while the queue is empty is not accepted and produces no response. It is accepted in the first cycle the queue holds an entry.
- R6: `trail_fault` is 1 together with a response exactly when the trailing request address differs from the address stored in the popped entry. It is 0 otherwise.
- R7: When the queue is neither full nor empty, a push and a pop in the same cycle both take effect and the occupancy stays the same.
- R8: When the queue is full, a pop in the same cycle as a leading return is accepted and the return is not. The occupancy drops by one.
- R9: When the queue is empty, a leading return in the same cycle as a trailing request is stored and the request is not accepted. The occupancy becomes one.
- R10: `q_empty` is 1 exactly at occupancy 0 and `q_full` is 1 exactly at occupancy DEPTH, across any number of wrap-arounds of the storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lead_vld | input | 1 | Leading-thread cache return valid |
| lead_addr | input | AW | Address of the leading load |
| lead_data | input | DW | Value returned by the cache |
| lead_stall | output | 1 | Leading returns must be held (queue full) |
| trail_vld | input | 1 | Trailing-thread load request |
| trail_addr | input | AW | Address of the trailing load |
| trail_rsp_vld | output | 1 | Response to the request accepted last cycle |
| trail_rsp_data | output | DW | Replicated load value |
| trail_fault | output | 1 | Address mismatch on the popped entry |
| q_full | output | 1 | Occupancy equals DEPTH |
| q_empty | output | 1 | Occupancy is zero |

## Verification
The bench pushes the queue into the full and empty states many times and hits every push/pop combination in each state. A design that let a push slip in while full would overwrite the oldest unread value. A design that bypassed an empty queue would answer a trailing load with stale or undefined data. Long runs make the ring indices wrap repeatedly, which exposes off-by-one errors in the wrap or in the full/empty flags as wrong pop data. Both matching and corrupted trailing addresses are applied, so a comparator that is inverted, compares against the wrong entry, or asserts the fault without a response is caught.

// File: rtl/leq_pkg.sv
package leq_pkg;

  // Advance a ring index, wrapping to zero after depth-1.
  function automatic logic [31:0] ring_next(input logic [31:0] idx,
                                            input logic [31:0] depth);
    if (idx + 32'd1 >= depth) return 32'd0;
    return idx + 32'd1;
  endfunction

  // Occupancy after one cycle of accepted pushes/pops.
  function automatic logic [31:0] occ_update(input logic [31:0] occ,
                                             input logic inc,
                                             input logic dec);
    logic [31:0] r;
    r = occ;
    if (inc && !dec) r = occ + 32'd1;
    if (dec && !inc) r = occ - 32'd1;
    return r;
  endfunction

endpackage

// File: rtl/leq_ctl.sv
module leq_ctl #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned PW    = 2,
  parameter int unsigned CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_fire,
  output logic          pop_fire,
  output logic [PW-1:0] wr_idx,
  output logic [PW-1:0] rd_idx,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] occ
);
  import leq_pkg::*;

  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] occ_q;

  assign full      = (occ_q == CW'(DEPTH));
  assign empty     = (occ_q == '0);
  assign push_fire = push_req && !full;
  assign pop_fire  = pop_req && !empty;
  assign wr_idx    = tail_q;
  assign rd_idx    = head_q;
  assign occ       = occ_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      if (push_fire) tail_q <= PW'(ring_next(32'(tail_q), 32'(DEPTH)));
      if (pop_fire)  head_q <= PW'(ring_next(32'(head_q), 32'(DEPTH)));
      occ_q <= CW'(occ_update(32'(occ_q), push_fire, pop_fire));
    end
  end

endmodule

// File: rtl/leq_store.sv
module leq_store #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned PW    = 2,
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] wr_idx,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] rd_idx,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [AW-1:0] slot_addr [DEPTH];
  logic [DW-1:0] slot_data [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_addr[g] <= '0;
        slot_data[g] <= '0;
      end else if (we && wr_idx == PW'(g)) begin
        slot_addr[g] <= wr_addr;
        slot_data[g] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_addr = '0;
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == PW'(i)) begin
        rd_addr = slot_addr[i];
        rd_data = slot_data[i];
      end
    end
  end

endmodule

// File: rtl/leq_resp.sv
module leq_resp #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop_fire,
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] ent_addr,
  input  logic [DW-1:0] ent_data,
  output logic          addr_mismatch,
  output logic          rsp_vld,
  output logic [DW-1:0] rsp_data,
  output logic          fault
);

  assign addr_mismatch = (req_addr != ent_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld  <= 1'b0;
      rsp_data <= '0;
      fault    <= 1'b0;
    end else begin
      rsp_vld <= pop_fire;
      fault   <= pop_fire && addr_mismatch;
      if (pop_fire) rsp_data <= ent_data;
    end
  end

endmodule

// File: rtl/load_echo_queue.sv
module load_echo_queue #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lead_vld,
  input  logic [AW-1:0] lead_addr,
  input  logic [DW-1:0] lead_data,
  output logic          lead_stall,
  input  logic          trail_vld,
  input  logic [AW-1:0] trail_addr,
  output logic          trail_rsp_vld,
  output logic [DW-1:0] trail_rsp_data,
  output logic          trail_fault,
  output logic          q_full,
  output logic          q_empty
);

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  // Named internal events, observed by the bound checker.
  logic          push_fire;
  logic          pop_fire;
  logic          addr_mismatch;
  logic [PW-1:0] wr_idx, rd_idx;
  logic [CW-1:0] occ;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data;

  leq_ctl #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .push_req(lead_vld), .pop_req(trail_vld),
    .push_fire(push_fire), .pop_fire(pop_fire),
    .wr_idx(wr_idx), .rd_idx(rd_idx),
    .full(q_full), .empty(q_empty), .occ(occ)
  );

  leq_store #(.DEPTH(DEPTH), .PW(PW), .AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(push_fire), .wr_idx(wr_idx),
    .wr_addr(lead_addr), .wr_data(lead_data),
    .rd_idx(rd_idx), .rd_addr(head_addr), .rd_data(head_data)
  );

  leq_resp #(.AW(AW), .DW(DW)) u_resp (
    .clk(clk), .rst_n(rst_n),
    .pop_fire(pop_fire), .req_addr(trail_addr),
    .ent_addr(head_addr), .ent_data(head_data),
    .addr_mismatch(addr_mismatch),
    .rsp_vld(trail_rsp_vld), .rsp_data(trail_rsp_data), .fault(trail_fault)
  );

  assign lead_stall = q_full;

endmodule

// File: rtl/leq_chk.sv
module leq_chk #(
  parameter int unsigned CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_fire,
  input logic          pop_fire,
  input logic [CW-1:0] occ,
  input logic          q_full,
  input logic          q_empty,
  input logic          trail_rsp_vld,
  input logic          trail_fault
);

  assert_reset_empty_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (q_empty && !q_full && !trail_rsp_vld));

  assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && !pop_fire) |=> (occ == $past(occ) + CW'(1)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !push_fire);

  assert_rsp_after_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> trail_rsp_vld);

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty |-> !pop_fire);

  assert_fault_with_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trail_fault |-> trail_rsp_vld);

  assert_occ_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && pop_fire) |=> $stable(occ));

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_full && q_empty));

endmodule

bind load_echo_queue leq_chk #(.CW(CW)) u_leq_chk (
  .clk(clk), .rst_n(rst_n),
  .push_fire(push_fire), .pop_fire(pop_fire), .occ(occ),
  .q_full(q_full), .q_empty(q_empty),
  .trail_rsp_vld(trail_rsp_vld), .trail_fault(trail_fault)
);

// File: tb/load_echo_queue_bench.sv
`timescale 1ns/1ps
module load_echo_queue_bench;
  localparam int D  = 4;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lead_vld = 1'b0, trail_vld = 1'b0;
  logic [AW-1:0] lead_addr = '0, trail_addr = '0;
  logic [DW-1:0] lead_data = '0;
  logic lead_stall, trail_rsp_vld, trail_fault, q_full, q_empty;
  logic [DW-1:0] trail_rsp_data;

  always #10 clk = ~clk;

  load_echo_queue #(.DEPTH(D), .AW(AW), .DW(DW)) u_load_echo_queue (
    .clk(clk), .rst_n(rst_n),
    .lead_vld(lead_vld), .lead_addr(lead_addr), .lead_data(lead_data),
    .lead_stall(lead_stall),
    .trail_vld(trail_vld), .trail_addr(trail_addr),
    .trail_rsp_vld(trail_rsp_vld), .trail_rsp_data(trail_rsp_data),
    .trail_fault(trail_fault), .q_full(q_full), .q_empty(q_empty)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int m_cnt = 0, m_head = 0, seq = 0;
  logic [AW-1:0] m_addr [D];
  logic [DW-1:0] m_data [D];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One cycle: inputs applied after a falling edge, outputs sampled 1 ns after the rising edge.
  task automatic step(input logic lv, input logic tv, input logic bad);
    bit e_push, e_pop;
    logic [DW-1:0] e_data;
    logic e_fault;
    string ctx;
    int tail;
    seq++;
    lead_vld  = lv;
    lead_addr = AW'(seq * 7 + 3);
    lead_data = DW'(seq) * 32'h9E37_79B1 + 32'h55;
    trail_vld = tv;
    if (m_cnt > 0) trail_addr = m_addr[m_head] ^ AW'(bad);
    else           trail_addr = 16'hBEEF ^ AW'(bad);
    #1;
    chk(lead_stall == (m_cnt == D), (m_cnt == D) ? "R3 stall" : "R2 stall",
        32'(lead_stall), 32'(m_cnt == D));
    chk(q_full == (m_cnt == D), "R10 full", 32'(q_full), 32'(m_cnt == D));
    chk(q_empty == (m_cnt == 0), "R10 empty", 32'(q_empty), 32'(m_cnt == 0));
    e_push  = lv && (m_cnt < D);
    e_pop   = tv && (m_cnt > 0);
    e_data  = m_data[m_head];
    e_fault = bad;
    if (m_cnt == D)       ctx = "R8 rsp";
    else if (m_cnt == 0)  ctx = (lv && tv) ? "R9 rsp" : "R5 rsp";
    else if (lv && tv)    ctx = "R7 rsp";
    else                  ctx = "R4 rsp";
    @(posedge clk);
    #1;
    chk(trail_rsp_vld == e_pop, ctx, 32'(trail_rsp_vld), 32'(e_pop));
    if (e_pop) begin
      chk(trail_rsp_data == e_data, "R4 data", trail_rsp_data, e_data);
      chk(trail_fault == e_fault, "R6 fault", 32'(trail_fault), 32'(e_fault));
    end else begin
      chk(trail_fault == 1'b0, "R6 idle fault", 32'(trail_fault), 0);
    end
    tail = (m_head + m_cnt) % D;
    if (e_push) begin
      m_addr[tail] = lead_addr;
      m_data[tail] = lead_data;
    end
    if (e_pop) m_head = (m_head + 1) % D;
    m_cnt = m_cnt + (e_push ? 1 : 0) - (e_pop ? 1 : 0);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < D; i++) begin
      m_addr[i] = '0;
      m_data[i] = '0;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(q_empty == 1'b1 && q_full == 1'b0, "R1 flags", {q_full, q_empty}, 32'h1);
    chk(trail_rsp_vld == 1'b0 && trail_fault == 1'b0 && lead_stall == 1'b0,
        "R1 outputs", {lead_stall, trail_rsp_vld, trail_fault}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R5: request while empty, then an entry arrives
    step(0, 1, 0); step(0, 1, 0);
    step(1, 1, 0);             // R9: push accepted, pop refused
    step(0, 1, 0);             // popped now
    // fill past full: R3
    for (int i = 0; i < D + 2; i++) step(1, 0, 0);
    step(1, 1, 1);             // R8 full with both, corrupted address
    step(1, 0, 0);
    // drain in order, mixing matching and corrupted addresses: R4, R6
    for (int i = 0; i < D + 1; i++) step(0, 1, i[0]);
    // sweep every combo at every occupancy level
    for (int lvl = 0; lvl <= D; lvl++) begin
      for (int c = 0; c < 8; c++) begin
        while (m_cnt < lvl) step(1, 0, 0);
        while (m_cnt > lvl) step(0, 1, 0);
        step(c[0], c[1], c[2]);
      end
    end
    // long pseudo-random run in three bias phases: R7, R10 wrap-around
    for (int ph = 0; ph < 3; ph++) begin
      for (int n = 0; n < 1500; n++) begin
        logic lv, tv;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        lv = (ph == 0) ? (lfsr[1:0] != 2'b00) : (ph == 1) ? lfsr[0] : (lfsr[1:0] == 2'b11);
        tv = (ph == 0) ? (lfsr[3:2] == 2'b11) : (ph == 1) ? lfsr[4] : (lfsr[3:2] != 2'b00);
        step(lv, tv, lfsr[7] & lfsr[9]);
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule